// File: doc/BRIEF.md
# Word Shifter with Carry Generation

This block is the shift slice of a 32-bit integer datapath. It performs logical left shifts, logical right shifts and arithmetic right shifts of a source word. Each operation completes in a single registered stage. The shift count comes from one of two places. The register forms take it from the low six bits of an amount word. The immediate form takes it from a separate 5-bit field.

Register-form counts of 32 to 63 give defined results rather than wrapping. Both arithmetic forms also produce a carry flag, which reports whether a negative value lost any 1 bits. A write enable is raised alongside the flag, so that the flag register outside the block is updated only by those arithmetic forms.

Top module: `word_shifter`

## Requirements
- R1: Operation code 0 is a logical left shift by amount word bits 5:0. When bit 5 is clear, the result is the source shifted left by bits 4:0, with zeros shifted in.
- R2: For operation codes 0 and 1, when amount word bit 5 is set, the result is zero.
- R3: Operation code 1 is a logical right shift by amount word bits 5:0. When bit 5 is clear, the result is the source shifted right by bits 4:0, with zeros shifted in.
- R4: Operation code 2 is an arithmetic right shift by amount word bits 5:0. When bit 5 is clear:
  - the result is the source shifted right by bits 4:0, filled with source bit 31;
  - carry is 1 exactly when source bit 31 is 1 and at least one 1 bit was shifted out;
  - an amount of zero returns the source unchanged with carry 0.
- R5: For operation code 2 with amount word bit 5 set:
  - the result is all ones for a negative source and zero otherwise;
  - carry is 1 exactly when the source is negative and has a 1 among bits 30:0.
- R6: Operation code 3 is an arithmetic right shift by the 5-bit immediate, with the same result and carry rule as R4. The amount word has no effect, and an immediate of zero returns the source with carry 0.
- R7: carry_we_o is 1 only in the output cycle of an operation with code 2 or 3. Operations with code 0 or 1 leave carry_o at its previous value.
- R8: valid_o is valid_i delayed by one clock. result_o and carry_o appear in that same cycle. Cycles without valid_i leave result_o and carry_o unchanged and keep valid_o and carry_we_o low.
- R9: During and after reset, before any operation, valid_o, carry_we_o, result_o and carry_o are all 0.
- R10: Amount word bits 31:6 have no effect on any register-form operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 shift left logical, 1 shift right logical, 2 shift right arithmetic by register, 3 shift right arithmetic by immediate |
| src_i | input | 32 | Word to shift |
| amt_i | input | 32 | Amount word for register forms (bits 5:0 used) |
| imm_i | input | 5 | Immediate amount for code 3 |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Registered shift result |
| carry_o | output | 1 | Carry flag from the most recent arithmetic shift |
| carry_we_o | output | 1 | Carry write enable, high for arithmetic forms only |

## Verification
Every fault in this block becomes visible at result_o or carry_o one cycle after the faulty operation. The stages are pure logic ahead of a single register, so no error can stay hidden for more than one cycle.

A wrong shift stage shows up at any amount that has the corresponding bit set. A wrong overflow decode shows up only at amounts 32 to 63. A lost-bit mask that is off by one shows up only for negative sources whose lowest set bit sits exactly at the shift boundary.

The bench therefore sweeps every amount for every operation, using sources that cover these cases. It also puts garbage in the unused amount bits. It tracks the expected carry across logical operations, so that any change to carry_o that should not happen is caught on the very next operation.

// File: rtl/word_shift_pkg.sv
package word_shift_pkg;

  typedef enum logic [1:0] {
    SH_LL_REG = 2'd0,
    SH_LR_REG = 2'd1,
    SH_AR_REG = 2'd2,
    SH_AR_IMM = 2'd3
  } shift_op_e;

  function automatic logic op_is_arith(shift_op_e op);
    return (op == SH_AR_REG) || (op == SH_AR_IMM);
  endfunction

endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel
  import word_shift_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  shift_op_e        op_i,
  input  logic [WIDTH-1:0] amt_word_i,
  input  logic [SHW-1:0]   imm_i,
  output logic [SHW-1:0]   amt_o,
  output logic             ovf_o,
  output logic             left_o,
  output logic             arith_o
);

  always_comb begin
    if (op_i == SH_AR_IMM) begin
      amt_o = imm_i;
      ovf_o = 1'b0;
    end else begin
      amt_o = amt_word_i[SHW-1:0];
      ovf_o = amt_word_i[SHW];
    end
    left_o  = (op_i == SH_LL_REG);
    arith_o = op_is_arith(op_i);
  end

endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             fill_i,
  input  logic             ovf_i,
  output logic [WIDTH-1:0] data_o
);

  function automatic logic [WIDTH-1:0] bit_rev(logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic [WIDTH-1:0] stage_d [SHW+1];
  logic             fill_q;

  // left shifts reuse the right shifter on the bit-reversed word
  assign fill_q     = fill_i & ~left_i;
  assign stage_d[0] = left_i ? bit_rev(data_i) : data_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage_d[s+1] = amt_i[s]
                        ? {{STEP{fill_q}}, stage_d[s][WIDTH-1:STEP]}
                        : stage_d[s];
  end

  always_comb begin
    if (ovf_i)       data_o = {WIDTH{fill_q}};
    else if (left_i) data_o = bit_rev(stage_d[SHW]);
    else             data_o = stage_d[SHW];
  end

endmodule

// File: rtl/shift_carry_gen.sv
module shift_carry_gen #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             ovf_i,
  input  logic             arith_i,
  output logic             carry_o
);

  logic [WIDTH-1:0] lost_mask;
  logic             lost_any;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) lost_mask[i] = (i < int'(amt_i));
    // with overflow every bit below the sign leaves the word
    if (ovf_i) lost_any = |data_i[WIDTH-2:0];
    else       lost_any = |(data_i & lost_mask);
    carry_o = arith_i & data_i[WIDTH-1] & lost_any;
  end

endmodule

// File: rtl/word_shifter.sv
module word_shifter
  import word_shift_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] amt_i,
  input  logic [SHW-1:0]   imm_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             carry_we_o
);

  shift_op_e        op;
  logic [SHW-1:0]   amt;
  logic             ovf, left, arith, carry_d;
  logic [WIDTH-1:0] res_d;

  assign op = shift_op_e'(op_i);

  shift_amount_sel #(.WIDTH(WIDTH)) i_sel (
    .op_i       (op),
    .amt_word_i (amt_i),
    .imm_i      (imm_i),
    .amt_o      (amt),
    .ovf_o      (ovf),
    .left_o     (left),
    .arith_o    (arith)
  );

  shift_barrel #(.WIDTH(WIDTH)) i_barrel (
    .data_i (src_i),
    .amt_i  (amt),
    .left_i (left),
    .fill_i (arith & src_i[WIDTH-1]),
    .ovf_i  (ovf),
    .data_o (res_d)
  );

  shift_carry_gen #(.WIDTH(WIDTH)) i_carry (
    .data_i  (src_i),
    .amt_i   (amt),
    .ovf_i   (ovf),
    .arith_i (arith),
    .carry_o (carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      carry_we_o <= 1'b0;
      result_o   <= '0;
      carry_o    <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      carry_we_o <= valid_i & arith;
      if (valid_i) result_o <= res_d;
      if (valid_i && arith) carry_o <= carry_d;
    end
  end

  p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !carry_we_o && $stable(result_o) && $stable(carry_o)));
  p_we_arith_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_we_o |-> valid_o);
  p_logic_carry_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[1]) |=> (!carry_we_o && $stable(carry_o)));
  p_ovf_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[1] && amt_i[SHW]) |=> (result_o == '0));
  p_ovf_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2 && amt_i[SHW]) |=>
      (result_o == {WIDTH{$past(src_i[WIDTH-1])}}));
  p_pos_no_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[1] && !src_i[WIDTH-1]) |=> !carry_o);
  p_imm_zero_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3 && imm_i == '0) |=>
      (result_o == $past(src_i) && !carry_o));

endmodule

// File: tb/test_word_shifter.sv
`timescale 1ns/1ps
module test_word_shifter;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] amt_i = '0;
  logic [4:0]  imm_i = '0;
  logic        valid_o, carry_o, carry_we_o;
  logic [31:0] result_o;

  int n_vec = 0;
  int n_bad = 0;
  logic exp_carry = 1'b0;
  bit   done = 1'b0;

  always #2 clk_i = ~clk_i;

  word_shifter i_word_shifter (
    .clk_i, .rst_ni, .valid_i, .op_i, .src_i, .amt_i, .imm_i,
    .valid_o, .result_o, .carry_o, .carry_we_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d src=%h amt=%h imm=%0d act=%h exp=%h",
               req, op_i, src_i, amt_i, imm_i, act, exp);
    end
  endtask

  function automatic void ref_model(input logic [1:0] op, input logic [31:0] src,
      input logic [31:0] amt, input logic [4:0] imm,
      output logic [31:0] res, output logic c);
    int n;
    n = (op == 2'd3) ? int'(imm) : int'(amt[5:0]);
    c = 1'b0;
    case (op)
      2'd0: res = (n >= 32) ? 32'h0 : src << n;
      2'd1: res = (n >= 32) ? 32'h0 : src >> n;
      default: begin
        if (n == 0) res = src;
        else if (n >= 32) begin
          res = {32{src[31]}};
          c = src[31] && (src[30:0] != 0);
        end else begin
          logic [31:0] lost;
          res  = $unsigned($signed(src) >>> n);
          lost = src << (32 - n);
          c = src[31] && (lost != 0);
        end
      end
    endcase
  endfunction

  task automatic apply(logic [1:0] op, logic [31:0] src, logic [31:0] amt, logic [4:0] imm);
    logic [31:0] er;
    logic ec;
    string tag;
    ref_model(op, src, amt, imm, er, ec);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; src_i = src; amt_i = amt; imm_i = imm;
    @(negedge clk_i);
    case (op)
      2'd0: tag = amt[5] ? "R2" : "R1";
      2'd1: tag = amt[5] ? "R2" : "R3";
      2'd2: tag = amt[5] ? "R5" : "R4";
      default: tag = "R6";
    endcase
    check(tag, result_o, er);
    if (op[1]) exp_carry = ec;
    check({tag, "/R7 carry"}, 32'(carry_o), 32'(exp_carry));
    check("R7 we", 32'(carry_we_o), 32'(op[1]));
    check("R8 valid", 32'(valid_o), 32'h1);
    valid_i = 1'b0;
  endtask

  initial begin
    logic [31:0] srcs [8];
    logic [31:0] last_res;
    srcs = '{32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
             32'h1234_5678, 32'hF0F0_F00F, 32'h0000_0001, 32'h8000_0100};
    #1;
    check("R9 valid", 32'(valid_o), 0);
    check("R9 result", result_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 valid", 32'(valid_o), 0);
    check("R9 we", 32'(carry_we_o), 0);
    check("R9 result", result_o, 0);
    check("R9 carry", 32'(carry_o), 0);

    foreach (srcs[k]) begin
      for (int op = 0; op < 3; op++) begin
        for (int a = 0; a < 64; a++) begin
          // R10: garbage in bits 31:6
          logic [31:0] junk;
          junk = (a % 2 == 0) ? 32'h0 : ((32'hA5C3_5F00 ^ (32'(k) << 12)) & ~32'h3F);
          apply(2'(op), srcs[k], junk | 32'(a), 5'd0);
        end
      end
      for (int a = 0; a < 32; a++)
        apply(2'd3, srcs[k], 32'hFFFF_FFC0 | 32'(31 - a), 5'(a)); // R6 amt ignored
    end

    // R8: idle cycle holds outputs
    apply(2'd2, 32'h8000_0003, 32'd1, 5'd0);
    last_res = result_o;
    @(negedge clk_i);
    check("R8 idle valid", 32'(valid_o), 0);
    check("R8 idle we", 32'(carry_we_o), 0);
    check("R8 idle result", result_o, last_res);
    check("R8 idle carry", 32'(carry_o), 32'(exp_carry));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule